// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block sits in the feedback path of a frequency synthesizer, after a fixed divide-by-8 prescaler and ahead of the phase detector. It divides its input clock by a programmable ratio N = 32·M + S. Each output period is split into M groups of input edges. The first S groups are 33 edges long and the rest are 32 edges long. A modulus-control output marks the long groups, so that a real dual-modulus stage could follow the same schedule. Inside this block the dual-modulus stage is modelled by counting input edges.

M and S are straight binary values. The block samples them only at the end of a period, so every period is built from one consistent pair. A mode input narrows M to 9 bits for the reduced-range mode. Values of M below 32 are raised to 32, so that M is never smaller than S and the swallow schedule always fits in the period.

The control path is a two-state machine. `ST_SWALLOW` counts 33-edge groups and drives the modulus control high. `ST_MAIN` counts 32-edge groups. The transitions are:
- reset entry: into `ST_SWALLOW` when S is non-zero, otherwise into `ST_MAIN`;
- `ST_SWALLOW` to `ST_MAIN`: when the S-th long group ends;
- `ST_MAIN` terminal count: when the M-th group ends. The machine reloads M and S, emits the output pulse, and re-enters `ST_SWALLOW` or `ST_MAIN` on the same rule as reset entry.

Top module: `psd_divider`

## Requirements
- R1: In wide mode (`narrow_m`=0), with M in 32..1023 on `m_in` and S in 0..31 on `s_in`, both plain binary, `div_pulse` pulses once every 32·M+S rising edges of `clk`.
- R2: Within each period, `mod_ctl` is high for exactly 33·S input edges at the start of the period (the first S groups) and low for the remaining 32·(M−S) edges. `mod_ctl` only rises in the cycle in which `div_pulse` is high.
- R3: `div_pulse` is high for exactly one `clk` cycle per period.
- R4: An effective M below 32 is treated as 32: for example, M=5, S=3 gives a period of 1027 edges, and M=0, S=0 gives 1024.
- R5: With `narrow_m`=1, only `m_in[8:0]` forms M. `m_in[9]` is ignored, so `m_in`=0x3FF gives M=511, and 0x220 gives M=32.
- R6: Values on `m_in`, `s_in` and `narrow_m` changed in the middle of a period do not alter that period. They take effect from the next period.
- R7: A synchronous active-high `rst` clears `div_pulse` and the counters, and loads M and S from the inputs. While `rst` is high, `mod_ctl` is high exactly when S is non-zero. The first pulse after release comes after exactly 32·M+S edges.
- R8: Consecutive pulses are never closer than 1024 edges and never further apart than 32767 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaled input clock; every rising edge is one counted edge |
| rst | input | 1 | Synchronous active-high reset |
| m_in | input | 10 | Main ratio M, binary |
| s_in | input | 5 | Swallow ratio S, binary |
| narrow_m | input | 1 | 1 = M limited to 9 bits |
| div_pulse | output | 1 | One-cycle pulse at each terminal count |
| mod_ctl | output | 1 | 1 = current group is 33 edges long |

## Verification
The assertions check on every cycle that the output pulse is a single cycle wide and that reset clears it. They also check that the modulus control rises only together with a terminal count, and that the spacing between pulses stays within the legal 1024..32767 band. What they cannot show is the exact period and the exact count of long-group edges for a given M and S. Nor can they show the clamp, the masking of the top M bit in narrow mode, or the rule that changes made mid-period wait for the next period. The directed scenarios measure these by counting edges and high samples of `mod_ctl` between pulses.

// File: rtl/psd_pkg.sv
`timescale 1ns/1ps
package psd_pkg;
    // Control phase of the swallow divider.
    typedef enum logic {
        ST_MAIN    = 1'b0,   // 32-edge groups
        ST_SWALLOW = 1'b1    // 33-edge groups
    } psd_state_t;
endpackage

// File: rtl/psd_ratio_sel.sv
`timescale 1ns/1ps
// Forms the effective M and S from the programmed inputs:
// narrow mode drops the top M bit, and M is raised to its floor.
module psd_ratio_sel #(
    parameter int M_W   = 10,
    parameter int S_W   = 5,
    parameter int M_MIN = 32
) (
    input  logic [M_W-1:0] m_raw,
    input  logic [S_W-1:0] s_raw,
    input  logic           narrow,
    output logic [M_W-1:0] m_eff,
    output logic [S_W-1:0] s_eff
);
    localparam logic [M_W-1:0] NARROW_MASK = {1'b0, {(M_W-1){1'b1}}};
    localparam logic [M_W-1:0] M_FLOOR     = M_W'(M_MIN);

    logic [M_W-1:0] m_masked;

    always_comb begin
        m_masked = narrow ? (m_raw & NARROW_MASK) : m_raw;
        m_eff    = (m_masked < M_FLOOR) ? M_FLOOR : m_masked;
    end

    assign s_eff = s_raw;
endmodule

// File: rtl/psd_group_cnt.sv
`timescale 1ns/1ps
// Models the dual-modulus stage: counts 2**S_W edges per group,
// or one more when mod_long is high.
module psd_group_cnt #(
    parameter int S_W = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic mod_long,
    output logic grp_end
);
    localparam int             CW         = S_W + 1;
    localparam logic [CW-1:0]  LAST_SHORT = CW'((1 << S_W) - 1);
    localparam logic [CW-1:0]  LAST_LONG  = CW'(1 << S_W);

    logic [CW-1:0] cnt;

    assign grp_end = (cnt == (mod_long ? LAST_LONG : LAST_SHORT));

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (grp_end) cnt <= '0;
        else              cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/psd_ctrl.sv
`timescale 1ns/1ps
// Swallow/main sequencing, per-period ratio latch and terminal pulse.
module psd_ctrl
    import psd_pkg::*;
#(
    parameter int M_W = 10,
    parameter int S_W = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           grp_end,
    input  logic [M_W-1:0] m_eff,
    input  logic [S_W-1:0] s_eff,
    output logic           div_pulse,
    output logic           mod_long
);
    psd_state_t     st, st_nx;
    logic [M_W-1:0] m_act, mn_cnt;
    logic [S_W-1:0] s_act, sw_cnt;
    logic           terminal;
    psd_state_t     entry_st;

    assign entry_st = (s_eff != '0) ? ST_SWALLOW : ST_MAIN;

    // Next state and terminal decode
    always_comb begin
        st_nx    = st;
        terminal = 1'b0;
        unique case (st)
            ST_SWALLOW: begin
                if (grp_end && (sw_cnt == s_act - S_W'(1)))
                    st_nx = ST_MAIN;
            end
            ST_MAIN: begin
                if (grp_end && (mn_cnt == m_act - M_W'(1))) begin
                    terminal = 1'b1;
                    st_nx    = entry_st;
                end
            end
            default: st_nx = ST_MAIN;
        endcase
    end

    // State register, counters and ratio latch
    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= entry_st;
            m_act  <= m_eff;
            s_act  <= s_eff;
            mn_cnt <= '0;
            sw_cnt <= '0;
        end else begin
            st <= st_nx;
            if (terminal) begin
                m_act  <= m_eff;
                s_act  <= s_eff;
                mn_cnt <= '0;
                sw_cnt <= '0;
            end else if (grp_end) begin
                mn_cnt <= mn_cnt + M_W'(1);
                if (st == ST_SWALLOW)
                    sw_cnt <= sw_cnt + S_W'(1);
            end
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) div_pulse <= 1'b0;
        else     div_pulse <= terminal;
    end

    assign mod_long = (st == ST_SWALLOW);
endmodule

// File: rtl/psd_divider.sv
`timescale 1ns/1ps
// Pulse-swallow feedback divider, N = 2**S_W * M + S.
module psd_divider #(
    parameter int M_W   = 10,
    parameter int S_W   = 5,
    parameter int M_MIN = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [M_W-1:0] m_in,
    input  logic [S_W-1:0] s_in,
    input  logic           narrow_m,
    output logic           div_pulse,
    output logic           mod_ctl
);
    logic [M_W-1:0] m_eff;
    logic [S_W-1:0] s_eff;
    logic           grp_end;

    psd_ratio_sel #(.M_W(M_W), .S_W(S_W), .M_MIN(M_MIN)) u_sel (
        .m_raw (m_in),
        .s_raw (s_in),
        .narrow(narrow_m),
        .m_eff (m_eff),
        .s_eff (s_eff)
    );

    psd_group_cnt #(.S_W(S_W)) u_grp (
        .clk     (clk),
        .rst     (rst),
        .mod_long(mod_ctl),
        .grp_end (grp_end)
    );

    psd_ctrl #(.M_W(M_W), .S_W(S_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .grp_end  (grp_end),
        .m_eff    (m_eff),
        .s_eff    (s_eff),
        .div_pulse(div_pulse),
        .mod_long (mod_ctl)
    );
endmodule

// File: rtl/psd_divider_chk.sv
`timescale 1ns/1ps
module psd_divider_chk #(
    parameter int M_W   = 10,
    parameter int S_W   = 5,
    parameter int M_MIN = 32
) (
    input logic clk,
    input logic rst,
    input logic div_pulse,
    input logic mod_ctl
);
    localparam int GAP_W = M_W + S_W + 1;
    localparam int MIN_N = M_MIN << S_W;
    localparam int MAX_N = (1 << (M_W + S_W)) - 1;

    logic [GAP_W-1:0] gap;
    logic             seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (div_pulse) begin
            gap  <= GAP_W'(1);
            seen <= 1'b1;
        end else if (gap != '1) begin
            gap <= gap + GAP_W'(1);
        end
    end

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    assert_reset_clear_R7: assert property (@(posedge clk)
        rst |=> !div_pulse);

    assert_mod_rise_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(mod_ctl) && !$past(rst)) |-> div_pulse);

    assert_period_bounds_R8: assert property (@(posedge clk) disable iff (rst)
        (div_pulse && seen) |-> (gap >= GAP_W'(MIN_N) && gap <= GAP_W'(MAX_N)));

    assert_gap_cap_R8: assert property (@(posedge clk) disable iff (rst)
        seen |-> (gap <= GAP_W'(MAX_N)));
endmodule

bind psd_divider psd_divider_chk #(.M_W(M_W), .S_W(S_W), .M_MIN(M_MIN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .div_pulse(div_pulse),
    .mod_ctl  (mod_ctl)
);

// File: tb/tb_psd_divider.sv
`timescale 1ns/1ps
module tb_psd_divider;
    localparam int M_W = 10;
    localparam int S_W = 5;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [M_W-1:0] m_in = '0;
    logic [S_W-1:0] s_in = '0;
    logic           narrow_m = 1'b0;
    logic           div_pulse, mod_ctl;

    int checks = 0, failures = 0;
    int cur_n = 0, cur_hi = 0;
    bit done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;   // 200 MHz

    psd_divider dut (
        .clk(clk), .rst(rst), .m_in(m_in), .s_in(s_in),
        .narrow_m(narrow_m), .div_pulse(div_pulse), .mod_ctl(mod_ctl)
    );

    function automatic int exp_n(input int m, input int s, input bit nw);
        int mm = nw ? (m & 511) : (m & 1023);
        if (mm < 32) mm = 32;
        return 32 * mm + s;
    endfunction

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Starts at a negedge where a pulse was seen (or reset was released);
    // optionally reprograms the inputs at sample 'at'.
    task automatic run_period(output int n, output int hi, input int at,
                              input int m, input int s, input bit nw);
        n = 0; hi = 0;
        forever begin
            if (mod_ctl) hi++;
            @(negedge clk);
            n++;
            if (n == at) begin
                m_in = M_W'(m); s_in = S_W'(s); narrow_m = nw;
            end
            if (div_pulse || n > 40000) break;
        end
    endtask

    task automatic measure(input string req, input int k);
        int n, hi;
        for (int i = 0; i < k; i++) begin
            run_period(n, hi, -1, 0, 0, 0);
            chk_eq(req, "period", n, cur_n);
            chk_eq("R2", "long-group edges", hi, cur_hi);
        end
    endtask

    // Reprogram in mid-period: current period must keep its old length (R6).
    task automatic retune(input int m, input int s, input bit nw);
        int n, hi;
        run_period(n, hi, 50, m, s, nw);
        chk_eq("R6", "period after mid change", n, cur_n);
        chk_eq("R6", "long edges after mid change", hi, cur_hi);
        cur_n  = exp_n(m, s, nw);
        cur_hi = 33 * s;
    endtask

    task automatic t_reset_start();
        int n, hi;
        m_in = 10'd100; s_in = 5'd7; narrow_m = 1'b0;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk_eq("R7", "pulse in reset", int'(div_pulse), 0);
        chk_eq("R7", "mod_ctl in reset, S=7", int'(mod_ctl), 1);
        cur_n = exp_n(100, 7, 0); cur_hi = 33 * 7;
        rst = 1'b0;
        run_period(n, hi, -1, 0, 0, 0);
        chk_eq("R7", "first period after reset", n, cur_n);
        chk_eq("R2", "first period long edges", hi, cur_hi);
        @(negedge clk);
        chk_eq("R3", "pulse width one cycle", int'(div_pulse), 0);
        // resync to the next pulse, then measure (R1)
        run_period(n, hi, -1, 0, 0, 0);
        chk_eq("R1", "period M=100 S=7", n + 1, cur_n);
    endtask

    task automatic t_reset_mid();
        int n, hi;
        repeat (300) @(negedge clk);
        rst = 1'b1;
        s_in = 5'd0;
        repeat (3) @(negedge clk);
        chk_eq("R7", "pulse cleared mid reset", int'(div_pulse), 0);
        chk_eq("R7", "mod_ctl in reset, S=0", int'(mod_ctl), 0);
        s_in = 5'd7;
        @(negedge clk);
        rst = 1'b0;
        run_period(n, hi, -1, 0, 0, 0);
        chk_eq("R7", "period after mid reset", n, cur_n);
        chk_eq("R2", "long edges after mid reset", hi, cur_hi);
    endtask

    task automatic t_basic();
        measure("R1", 1);
        retune(32, 0, 0);   measure("R1", 2);
        retune(32, 31, 0);  measure("R1", 2);
    endtask

    task automatic t_clamp();
        retune(5, 3, 0);    measure("R4", 1);
        retune(0, 0, 0);    measure("R4", 1);
    endtask

    task automatic t_max();
        retune(1023, 31, 0); measure("R1", 1);
    endtask

    task automatic t_narrow();
        retune(10'h3FF, 9, 1); measure("R5", 1);
        retune(10'h220, 4, 1); measure("R5", 1);
        retune(10'h205, 2, 1); measure("R5", 1);
    endtask

    task automatic t_random();
        for (int i = 0; i < 4; i++) begin
            int m, s; bit nw;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            m  = 32 + (int'(lfsr) % 96);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            s  = int'(lfsr) % 32;
            nw = lfsr[7];
            retune(m, s, nw);
            measure("R1", 1);
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL R1 watchdog actual=195000 expected=fewer cycles");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset_start();
        t_reset_mid();
        t_basic();
        t_clamp();
        t_max();
        t_narrow();
        t_random();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule